// File: doc/BRIEF.md
# CPU Register File with Trap Context

This block is the architectural register store of a 32-bit processor core. It holds eight general-purpose words, an instruction pointer, a stack pointer, a flags word, three save slots that capture the execution context on a trap, and a page-directory base. The execute stage reads two operands through combinational ports and writes one result per cycle. A separate command input drives the control-flow side effects: subroutine call and return, trap entry and exit, kernel call, and the stack pointer steps around push and pop. The block works out the stack address for each push and pop.

Privilege comes from bit 16 of the flags word (1 = supervisor). In user mode the block drops writeback to the privileged registers and to the upper half of the flags word. It reports a dropped write by raising a pulse on `priv_fault` for one cycle. A trap saves the instruction pointer, stack pointer and flags in a single clock edge, and a trap return restores all three in a single edge. Software therefore returns to the saved mode without going through a window in which only part of the context has been restored.

Top module: `cpu_regfile`

## Requirements
- R1: While reset is high, every register is cleared to zero on each clock edge, except the flags word, which loads 0x0001_0000 (supervisor bit 16 set). `priv_fault` is low after reset.
- R2: Register indices are: 0 to 7 general purpose, 8 instruction pointer, 9 stack pointer, 10 flags, 11/12/13 save slots 0/1/2, 14 page-directory base. Index 15 reads as zero, and a writeback to index 15 changes no register.
- R3: With `wb_en` high, `wb_data` is stored into register `wb_idx` at the clock edge. In the same cycle, a read port addressing that register already returns the value being written.
- R4: Command 1 (call) copies the instruction pointer into save slot 0 and loads the instruction pointer from `tgt`. Command 2 (return) loads the instruction pointer from save slot 0.
- R5: Command 3 (trap) copies the instruction pointer, stack pointer and flags into save slots 0, 1 and 2 at the same edge and loads the instruction pointer from `tgt`. Command 5 (kernel call) does the same but loads the fixed vector KCALL_VEC (default 0x100) and ignores `tgt`.
- R6: Command 4 (trap return) loads the instruction pointer, stack pointer and flags from save slots 0, 1 and 2 at the same edge, which restores the saved privilege mode.
- R7: Command 6 (push) presents stack pointer + 1 on `stk_addr` and increments the stack pointer. Command 7 (pop) presents the current stack pointer and decrements it. With any other command, `stk_addr` equals the stack pointer.
- R8: In user mode (flags bit 16 = 0), a writeback to the flags word changes only bits 15:0, and writebacks to indices 11 to 14 are dropped. Reads of the flags word through a read port return bits 31:16 as zero. Bits 0 (carry) and 1 (overflow) stay writable.
- R9: `priv_fault` is high for the single cycle after a user-mode writeback to index 11 to 14, or to the flags word with `wb_data[31:16]` different from the current flags bits 31:16. In every other case it is low.
- R10: When a command and a writeback target the same register in one cycle, the command's value is stored and also shown by the read ports. A writeback to a register the command does not touch still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data (bypassed) |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data (bypassed) |
| wb_en | input | 1 | Writeback enable |
| wb_idx | input | 4 | Writeback register index |
| wb_data | input | 32 | Writeback data |
| cmd | input | 3 | Control command (0 none, 1 call, 2 return, 3 trap, 4 trap return, 5 kernel call, 6 push, 7 pop) |
| tgt | input | 32 | Target address for call and trap |
| stk_addr | output | 32 | Stack memory address for push or pop |
| ip | output | 32 | Current instruction pointer |
| sp | output | 32 | Current stack pointer |
| flags | output | 32 | Current flags word, unmasked |
| supervisor | output | 1 | Current privilege mode |
| priv_fault | output | 1 | One-cycle privilege violation pulse |

## Verification
The situation hardest to reach from the ports is user mode followed by a clean return to supervisor mode. The block comes out of reset in supervisor mode. Once the supervisor bit is cleared, nothing except a trap return can set it again. The stimulus therefore first places a flags value with an extra upper bit into the flags word and traps, so that save slot 2 holds a supervisor context. It then clears the supervisor bit with a privileged writeback. The violation cases run in user mode and the bench observes the read-port masking there. A trap return then restores the saved flags, and the bench confirms that the mode and the extra upper bit are both back.

// File: rtl/regfile_pkg.sv
package regfile_pkg;
  localparam int RF_IDX_W = 4;
  localparam int RF_NREG  = 15;

  localparam int IDX_IP  = 8;
  localparam int IDX_SP  = 9;
  localparam int IDX_FLG = 10;
  localparam int IDX_SV0 = 11;
  localparam int IDX_SV1 = 12;
  localparam int IDX_SV2 = 13;
  localparam int IDX_PGD = 14;

  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_CALL  = 3'd1,
    CMD_RET   = 3'd2,
    CMD_TRAP  = 3'd3,
    CMD_TRET  = 3'd4,
    CMD_KCALL = 3'd5,
    CMD_PUSH  = 3'd6,
    CMD_POP   = 3'd7
  } rf_cmd_e;

  // Indices 11..14 need supervisor mode for writeback.
  function automatic logic idx_is_priv(input logic [RF_IDX_W-1:0] idx);
    return (idx >= RF_IDX_W'(IDX_SV0)) && (idx <= RF_IDX_W'(IDX_PGD));
  endfunction
endpackage

// File: rtl/rf_priv_gate.sv
module rf_priv_gate
  import regfile_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = RF_NREG
) (
  input  logic                  wb_en,
  input  logic [RF_IDX_W-1:0]   wb_idx,
  input  logic [XLEN-1:0]       wb_data,
  input  logic [XLEN/2-1:0]     flg_hi,
  output logic [NREG-1:0]       wb_we,
  output logic [XLEN-1:0]       wb_mask,
  output logic                  viol
);
  localparam int HALF = XLEN / 2;

  logic sup;
  logic hit;
  assign sup = flg_hi[0];

  always_comb begin
    hit     = wb_en;
    viol    = 1'b0;
    wb_mask = '1;
    if (wb_en && idx_is_priv(wb_idx) && !sup) begin
      hit  = 1'b0;
      viol = 1'b1;
    end
    if (wb_en && (wb_idx == RF_IDX_W'(IDX_FLG)) && !sup) begin
      wb_mask = {{HALF{1'b0}}, {HALF{1'b1}}};
      if (wb_data[XLEN-1:HALF] != flg_hi) viol = 1'b1;
    end
  end

  for (genvar i = 0; i < NREG; i++) begin : g_we
    assign wb_we[i] = hit && (wb_idx == RF_IDX_W'(i));
  end
endmodule

// File: rtl/rf_side_ctrl.sv
module rf_side_ctrl
  import regfile_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              NREG      = RF_NREG,
  parameter logic [XLEN-1:0] KCALL_VEC = 32'h100
) (
  input  rf_cmd_e                    cmd,
  input  logic [XLEN-1:0]            tgt,
  input  logic [XLEN-1:0]            cur_ip,
  input  logic [XLEN-1:0]            cur_sp,
  input  logic [XLEN-1:0]            cur_flg,
  input  logic [XLEN-1:0]            cur_sv0,
  input  logic [XLEN-1:0]            cur_sv1,
  input  logic [XLEN-1:0]            cur_sv2,
  output logic [NREG-1:0]            sb_we,
  output logic [NREG-1:0][XLEN-1:0]  sb_data
);
  always_comb begin
    sb_we   = '0;
    sb_data = '0;
    unique case (cmd)
      CMD_CALL: begin
        sb_we[IDX_SV0] = 1'b1; sb_data[IDX_SV0] = cur_ip;
        sb_we[IDX_IP]  = 1'b1; sb_data[IDX_IP]  = tgt;
      end
      CMD_RET: begin
        sb_we[IDX_IP] = 1'b1; sb_data[IDX_IP] = cur_sv0;
      end
      CMD_TRAP, CMD_KCALL: begin
        sb_we[IDX_SV0] = 1'b1; sb_data[IDX_SV0] = cur_ip;
        sb_we[IDX_SV1] = 1'b1; sb_data[IDX_SV1] = cur_sp;
        sb_we[IDX_SV2] = 1'b1; sb_data[IDX_SV2] = cur_flg;
        sb_we[IDX_IP]  = 1'b1;
        sb_data[IDX_IP] = (cmd == CMD_TRAP) ? tgt : KCALL_VEC;
      end
      CMD_TRET: begin
        sb_we[IDX_IP]  = 1'b1; sb_data[IDX_IP]  = cur_sv0;
        sb_we[IDX_SP]  = 1'b1; sb_data[IDX_SP]  = cur_sv1;
        sb_we[IDX_FLG] = 1'b1; sb_data[IDX_FLG] = cur_sv2;
      end
      CMD_PUSH: begin
        sb_we[IDX_SP] = 1'b1; sb_data[IDX_SP] = cur_sp + XLEN'(1);
      end
      CMD_POP: begin
        sb_we[IDX_SP] = 1'b1; sb_data[IDX_SP] = cur_sp - XLEN'(1);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rf_store.sv
module rf_store
  import regfile_pkg::*;
#(
  parameter int              XLEN    = 32,
  parameter int              NREG    = RF_NREG,
  parameter logic [XLEN-1:0] FLG_RST = 32'h0001_0000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NREG-1:0]            wb_we,
  input  logic [XLEN-1:0]            wb_mask,
  input  logic [XLEN-1:0]            wb_data,
  input  logic [NREG-1:0]            sb_we,
  input  logic [NREG-1:0][XLEN-1:0]  sb_data,
  output logic [NREG-1:0][XLEN-1:0]  cur,
  output logic [NREG-1:0][XLEN-1:0]  nxt
);
  always_comb begin
    for (int i = 0; i < NREG; i++) begin
      if (sb_we[i])
        nxt[i] = sb_data[i];
      else if (wb_we[i])
        nxt[i] = (cur[i] & ~wb_mask) | (wb_data & wb_mask);
      else
        nxt[i] = cur[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur          <= '0;
      cur[IDX_FLG] <= FLG_RST;
    end else begin
      cur <= nxt;
    end
  end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import regfile_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NREG = RF_NREG
) (
  input  logic [RF_IDX_W-1:0]        idx,
  input  logic [NREG-1:0][XLEN-1:0]  nxt,
  input  logic                       sup,
  output logic [XLEN-1:0]            data
);
  localparam int HALF = XLEN / 2;

  always_comb begin
    data = '0;
    for (int i = 0; i < NREG; i++)
      if (idx == RF_IDX_W'(i)) data = nxt[i];
    if ((idx == RF_IDX_W'(IDX_FLG)) && !sup)
      data[XLEN-1:HALF] = '0;
  end
endmodule

// File: rtl/cpu_regfile.sv
module cpu_regfile
  import regfile_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] KCALL_VEC = 32'h100
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [RF_IDX_W-1:0]  rd_a_idx,
  output logic [XLEN-1:0]      rd_a_data,
  input  logic [RF_IDX_W-1:0]  rd_b_idx,
  output logic [XLEN-1:0]      rd_b_data,
  input  logic                 wb_en,
  input  logic [RF_IDX_W-1:0]  wb_idx,
  input  logic [XLEN-1:0]      wb_data,
  input  logic [2:0]           cmd,
  input  logic [XLEN-1:0]      tgt,
  output logic [XLEN-1:0]      stk_addr,
  output logic [XLEN-1:0]      ip,
  output logic [XLEN-1:0]      sp,
  output logic [XLEN-1:0]      flags,
  output logic                 supervisor,
  output logic                 priv_fault
);
  localparam int              NREG    = RF_NREG;
  localparam int              HALF    = XLEN / 2;
  localparam logic [XLEN-1:0] FLG_RST = XLEN'(1) << HALF;

  rf_cmd_e                   cmd_e;
  logic [NREG-1:0][XLEN-1:0] cur;
  logic [NREG-1:0][XLEN-1:0] nxt;
  logic [NREG-1:0]           wb_we;
  logic [XLEN-1:0]           wb_mask;
  logic                      viol;
  logic [NREG-1:0]           sb_we;
  logic [NREG-1:0][XLEN-1:0] sb_data;

  assign cmd_e = rf_cmd_e'(cmd);

  rf_priv_gate #(.XLEN(XLEN), .NREG(NREG)) u_gate (
    .wb_en   (wb_en),
    .wb_idx  (wb_idx),
    .wb_data (wb_data),
    .flg_hi  (cur[IDX_FLG][XLEN-1:HALF]),
    .wb_we   (wb_we),
    .wb_mask (wb_mask),
    .viol    (viol)
  );

  rf_side_ctrl #(.XLEN(XLEN), .NREG(NREG), .KCALL_VEC(KCALL_VEC)) u_side (
    .cmd     (cmd_e),
    .tgt     (tgt),
    .cur_ip  (cur[IDX_IP]),
    .cur_sp  (cur[IDX_SP]),
    .cur_flg (cur[IDX_FLG]),
    .cur_sv0 (cur[IDX_SV0]),
    .cur_sv1 (cur[IDX_SV1]),
    .cur_sv2 (cur[IDX_SV2]),
    .sb_we   (sb_we),
    .sb_data (sb_data)
  );

  rf_store #(.XLEN(XLEN), .NREG(NREG), .FLG_RST(FLG_RST)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wb_we   (wb_we),
    .wb_mask (wb_mask),
    .wb_data (wb_data),
    .sb_we   (sb_we),
    .sb_data (sb_data),
    .cur     (cur),
    .nxt     (nxt)
  );

  rf_read_port #(.XLEN(XLEN), .NREG(NREG)) u_rd_a (
    .idx (rd_a_idx), .nxt (nxt), .sup (supervisor), .data (rd_a_data)
  );

  rf_read_port #(.XLEN(XLEN), .NREG(NREG)) u_rd_b (
    .idx (rd_b_idx), .nxt (nxt), .sup (supervisor), .data (rd_b_data)
  );

  assign ip         = cur[IDX_IP];
  assign sp         = cur[IDX_SP];
  assign flags      = cur[IDX_FLG];
  assign supervisor = cur[IDX_FLG][HALF];
  assign stk_addr   = (cmd_e == CMD_PUSH) ? cur[IDX_SP] + XLEN'(1) : cur[IDX_SP];

  always_ff @(posedge clk) begin
    if (rst) priv_fault <= 1'b0;
    else     priv_fault <= viol;
  end
endmodule

// File: rtl/cpu_regfile_chk.sv
module cpu_regfile_chk
  import regfile_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] KCALL_VEC = 32'h100
) (
  input logic                 clk,
  input logic                 rst,
  input logic [2:0]           cmd,
  input logic [XLEN-1:0]      tgt,
  input logic                 wb_en,
  input logic [RF_IDX_W-1:0]  wb_idx,
  input logic [XLEN-1:0]      stk_addr,
  input logic [XLEN-1:0]      ip,
  input logic [XLEN-1:0]      sp,
  input logic [XLEN-1:0]      flags,
  input logic                 priv_fault,
  input logic [XLEN-1:0]      sv0,
  input logic [XLEN-1:0]      sv1,
  input logic [XLEN-1:0]      sv2,
  input logic [XLEN-1:0]      pgd
);
  localparam int              HALF    = XLEN / 2;
  localparam logic [XLEN-1:0] FLG_RST = XLEN'(1) << HALF;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (flags == FLG_RST) && (ip == '0) && (sp == '0) && !priv_fault);

  a_r4_call: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_CALL) |=> (ip == $past(tgt)) && (sv0 == $past(ip)));

  a_r5_trap_save: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_TRAP) |=> (sv0 == $past(ip)) && (sv1 == $past(sp))
                          && (sv2 == $past(flags)) && (ip == $past(tgt)));

  a_r5_kcall_vec: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_KCALL) |=> (ip == KCALL_VEC) && (sv2 == $past(flags)));

  a_r6_trap_return: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_TRET) |=> (ip == $past(sv0)) && (sp == $past(sv1))
                          && (flags == $past(sv2)));

  a_r7_push_addr: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_PUSH) |-> (stk_addr == sp + XLEN'(1)));

  a_r7_pop_step: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_POP) |=> (sp == $past(sp) - XLEN'(1)));

  a_r8_upper_held: assert property (@(posedge clk) disable iff (rst)
    (!flags[HALF] && (cmd != CMD_TRET)) |=> (flags[XLEN-1:HALF] == $past(flags[XLEN-1:HALF])));

  a_r8_pgd_held: assert property (@(posedge clk) disable iff (rst)
    !flags[HALF] |=> $stable(pgd));

  a_r9_no_fault_gp: assert property (@(posedge clk) disable iff (rst)
    (!wb_en || (wb_idx < RF_IDX_W'(IDX_IP))) |=> !priv_fault);
endmodule

bind cpu_regfile cpu_regfile_chk #(.XLEN(XLEN), .KCALL_VEC(KCALL_VEC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd        (cmd),
  .tgt        (tgt),
  .wb_en      (wb_en),
  .wb_idx     (wb_idx),
  .stk_addr   (stk_addr),
  .ip         (ip),
  .sp         (sp),
  .flags      (flags),
  .priv_fault (priv_fault),
  .sv0        (cur[11]),
  .sv1        (cur[12]),
  .sv2        (cur[13]),
  .pgd        (cur[14])
);

// File: tb/cpu_regfile_tb.sv
`timescale 1ns/1ps
module cpu_regfile_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  rd_a_idx, rd_b_idx, wb_idx;
  logic [31:0] rd_a_data, rd_b_data, wb_data, tgt;
  logic        wb_en;
  logic [2:0]  cmd;
  logic [31:0] stk_addr, ip, sp, flags;
  logic        supervisor, priv_fault;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  cpu_regfile u_dut (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
    .cmd(cmd), .tgt(tgt), .stk_addr(stk_addr),
    .ip(ip), .sp(sp), .flags(flags),
    .supervisor(supervisor), .priv_fault(priv_fault)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic peek(input logic [3:0] idx, output logic [31:0] v);
    rd_b_idx = idx;
    #1;
    v = rd_b_data;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [31:0] d);
    wb_en = 1'b1; wb_idx = idx; wb_data = d;
    tick();
    wb_en = 1'b0;
  endtask

  task automatic go(input logic [2:0] c, input logic [31:0] t);
    cmd = c; tgt = t;
    tick();
    cmd = 3'd0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rst = 1'b1; wb_en = 1'b0; wb_idx = '0; wb_data = '0;
    cmd = '0; tgt = '0; rd_a_idx = '0; rd_b_idx = '0;
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R1", "ip", ip, 32'h0);
    chk("R1", "sp", sp, 32'h0);
    chk("R1", "flags", flags, 32'h0001_0000);
    chk("R1", "supervisor", {31'b0, supervisor}, 32'h1);
    chk("R1", "priv_fault", {31'b0, priv_fault}, 32'h0);
    peek(4'd14, v); chk("R1", "pgdir", v, 32'h0);
  endtask

  task automatic t_gp();
    logic [31:0] v;
    wb_en = 1'b1; wb_idx = 4'd3; wb_data = 32'hA5A5_0003;
    rd_a_idx = 4'd3; rd_b_idx = 4'd2;
    #1;
    chk("R3", "bypass port A", rd_a_data, 32'hA5A5_0003);
    chk("R3", "other reg port B", rd_b_data, 32'h0);
    tick(); wb_en = 1'b0;
    peek(4'd3, v); chk("R3", "stored gp3", v, 32'hA5A5_0003);
    wr(4'd7, 32'h7777_0007);
    peek(4'd7, v); chk("R2", "gp7", v, 32'h7777_0007);
    wr(4'd14, 32'h1234_5000);
    peek(4'd14, v); chk("R2", "pgdir sup write", v, 32'h1234_5000);
    wr(4'd15, 32'hFFFF_FFFF);
    peek(4'd15, v); chk("R2", "index 15 reads zero", v, 32'h0);
    peek(4'd14, v); chk("R2", "index 15 write harmless", v, 32'h1234_5000);
  endtask

  task automatic t_call_ret();
    logic [31:0] v;
    wr(4'd8, 32'h40);
    chk("R2", "ip via wb", ip, 32'h40);
    go(3'd1, 32'h200);
    chk("R4", "call ip", ip, 32'h200);
    peek(4'd11, v); chk("R4", "call save0", v, 32'h40);
    go(3'd2, 32'hDEAD);
    chk("R4", "return ip", ip, 32'h40);
  endtask

  task automatic t_push_pop();
    wr(4'd9, 32'h80);
    cmd = 3'd6; #1;
    chk("R7", "push addr", stk_addr, 32'h81);
    tick(); cmd = 3'd0;
    chk("R7", "push sp", sp, 32'h81);
    cmd = 3'd7; #1;
    chk("R7", "pop addr", stk_addr, 32'h81);
    tick(); cmd = 3'd0; #1;
    chk("R7", "pop sp", sp, 32'h80);
    chk("R7", "idle addr", stk_addr, 32'h80);
  endtask

  task automatic t_trap();
    logic [31:0] v;
    wr(4'd10, 32'h0001_0003);
    go(3'd3, 32'h900);
    chk("R5", "trap ip", ip, 32'h900);
    peek(4'd11, v); chk("R5", "trap save0", v, 32'h40);
    peek(4'd12, v); chk("R5", "trap save1", v, 32'h80);
    peek(4'd13, v); chk("R5", "trap save2", v, 32'h0001_0003);
    wr(4'd9, 32'h300);
    wr(4'd10, 32'h0001_00F0);
    go(3'd4, 32'h0);
    chk("R6", "tret ip", ip, 32'h40);
    chk("R6", "tret sp", sp, 32'h80);
    chk("R6", "tret flags", flags, 32'h0001_0003);
    go(3'd5, 32'hABC);
    chk("R5", "kcall ip", ip, 32'h100);
    peek(4'd11, v); chk("R5", "kcall save0", v, 32'h40);
    peek(4'd13, v); chk("R5", "kcall save2", v, 32'h0001_0003);
  endtask

  task automatic t_user();
    logic [31:0] v;
    wr(4'd10, 32'h0003_0000);
    go(3'd3, 32'h500);
    wr(4'd10, 32'h0002_0005);
    chk("R9", "sup write no fault", {31'b0, priv_fault}, 32'h0);
    chk("R8", "user mode entered", {31'b0, supervisor}, 32'h0);
    peek(4'd10, v); chk("R8", "flags read masked", v, 32'h0000_0005);
    chk("R8", "flags port raw", flags, 32'h0002_0005);
    wr(4'd10, 32'h0002_0009);
    chk("R8", "lower write", flags, 32'h0002_0009);
    chk("R9", "same upper no fault", {31'b0, priv_fault}, 32'h0);
    wr(4'd10, 32'hFFFF_0002);
    chk("R8", "upper dropped", flags, 32'h0002_0002);
    chk("R9", "upper change fault", {31'b0, priv_fault}, 32'h1);
    tick();
    chk("R9", "fault one cycle", {31'b0, priv_fault}, 32'h0);
    wr(4'd14, 32'h0000_DEAD);
    chk("R9", "pgdir fault", {31'b0, priv_fault}, 32'h1);
    peek(4'd14, v); chk("R8", "pgdir dropped", v, 32'h1234_5000);
    wr(4'd12, 32'h0000_BEEF);
    peek(4'd12, v); chk("R8", "save1 dropped", v, 32'h80);
    wr(4'd5, 32'h0000_0055);
    chk("R9", "gp write no fault", {31'b0, priv_fault}, 32'h0);
    peek(4'd5, v); chk("R8", "user gp write", v, 32'h0000_0055);
    go(3'd4, 32'h0);
    chk("R6", "back to supervisor", {31'b0, supervisor}, 32'h1);
    chk("R6", "flags restored", flags, 32'h0003_0000);
  endtask

  task automatic t_conflict();
    logic [31:0] v;
    cmd = 3'd1; tgt = 32'h700;
    wb_en = 1'b1; wb_idx = 4'd8; wb_data = 32'h999;
    rd_a_idx = 4'd8; #1;
    chk("R10", "read shows command", rd_a_data, 32'h700);
    tick(); cmd = 3'd0; wb_en = 1'b0;
    chk("R10", "command wins ip", ip, 32'h700);
    cmd = 3'd6; wb_en = 1'b1; wb_idx = 4'd1; wb_data = 32'h55;
    tick(); cmd = 3'd0; wb_en = 1'b0;
    peek(4'd1, v); chk("R10", "other wb kept", v, 32'h55);
    chk("R10", "push with wb", sp, 32'h81);
  endtask

  initial begin
    t_reset();
    t_gp();
    t_call_ret();
    t_push_pop();
    t_trap();
    t_user();
    t_conflict();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule